// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block turns single requests from an internal port (address, write data, direction, strobe) into accesses on an external parallel bus where the low address byte and the data byte share one set of 8 bidirectional pins. Each access has two phases. In the address phase the latch-enable output is high and the low address byte is driven. The falling edge of the latch enable tells an external transparent latch to hold that byte. In the data phase the active-low read or write strobe is pulsed and the shared pins carry data. The controller produces the latch enable for every access by itself. The setup, pulse and hold lengths of each phase are parameters.

The upper address pins are shared with general-purpose outputs. When `wide_i` is low (8-bit, non-banked), those pins carry the `gpio_hi_i` value and the external address is 8 bits. When `wide_i` is high (banked or wider mode), the pins carry address bits [11:8], which gives a 12-bit external address. The internal side sees a one-cycle `done_o` pulse when an access ends. For a read, the captured byte is presented on `rdata_o` and stays there until the next read.

Top module: `muxbus_ctrl`

## Requirements
- R1: During reset and whenever the block is idle: `ale_o`=0, `rd_no`=1, `wr_no`=1, `ad_oe_o`=0 and `done_o`=0. `idle_o`=1 after reset.
- R2: A request is accepted on a clock edge where `req_i`=1 and `idle_o`=1. For the next ADDR_CYC cycles, `ale_o`=1, `ad_oe_o`=1 and `ad_o`=address bits [7:0].
- R3: After `ale_o` falls, `ad_o` keeps the low address byte for LATCH_CYC cycles (at least 1). No strobe goes low earlier than LATCH_CYC+1 cycles after the fall, so the first strobe cycle is cycle ADDR_CYC+LATCH_CYC+2 after acceptance.
- R4: A write (`we_i`=1) holds `wr_no` low for exactly STROBE_CYC cycles. `ad_oe_o`=1 and `ad_o`=write data from the cycle before the strobe through the end of the hold phase.
- R5: A read holds `rd_no` low for exactly STROBE_CYC cycles. `ad_oe_o`=0 for the cycle before the strobe, for every strobe cycle, and for the cycle after it.
- R6: Read data is sampled from `ad_i` on the edge where `rd_no` returns high. It appears on `rdata_o` by the time `done_o` pulses and is held until the next read.
- R7: `done_o` is high for exactly one cycle, ADDR_CYC+LATCH_CYC+STROBE_CYC+HOLD_CYC+2 cycles after the accepting edge. `idle_o` is high in that same cycle.
- R8: A `req_i` that arrives while `idle_o`=0 is ignored. It causes no extra access and no extra `done_o`, and the external memory is left unchanged.
- R9: With `wide_i`=1, `hi_o` carries address bits [11:8] of the current access. With `wide_i`=0, `hi_o` follows `gpio_hi_i`.
- R10: `rd_no` and `wr_no` are never low at the same time, and `ale_o` is never high while a strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, taken only when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Access address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Last read data |
| done_o | output | 1 | One-cycle completion pulse |
| idle_o | output | 1 | Block can accept a request |
| wide_i | input | 1 | 1 = drive upper address pins, 0 = pins follow GPIO |
| gpio_hi_i | input | 4 | GPIO value for the upper pins in narrow mode |
| ale_o | output | 1 | Address latch enable |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| ad_o | output | 8 | Shared address/data bus, output value |
| ad_oe_o | output | 1 | Output enable for the shared bus |
| ad_i | input | 8 | Shared address/data bus, input value |
| hi_o | output | 4 | Upper address nibble or GPIO |

## Verification
The assertions assume that `wide_i` stays constant from acceptance to completion, because the stability check on `hi_o` depends on it. The bench changes the mode only while the block is idle. The assertions make no assumption about `ad_i`, which may hold any value outside a read strobe. The bench's memory model drives a marker value there so that a sample taken at the wrong time shows up in the read data. Requests that arrive while the block is busy are legal, and the bench injects them on purpose.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ADDR   = 3'd1,
      ST_LATCH  = 3'd2,
      ST_TURN   = 3'd3,
      ST_STROBE = 3'd4,
      ST_HOLD   = 3'd5
   } mb_state_e;

   typedef struct packed {
      logic ale;
      logic rd_act;
      logic wr_act;
      logic oe;
      logic sel_data;
   } mb_ctl_t;
endpackage

// File: rtl/muxbus_seq.sv
module muxbus_seq
   import muxbus_pkg::*;
#(
   parameter int ADDR_CYC   = 2,
   parameter int LATCH_CYC  = 1,
   parameter int STROBE_CYC = 3,
   parameter int HOLD_CYC   = 1
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      start_i,
   input  logic      we_i,
   output mb_state_e state_o,
   output mb_ctl_t   ctl_o,
   output logic      cap_o,
   output logic      done_o
);
   localparam int MAX_A = (ADDR_CYC > LATCH_CYC) ? ADDR_CYC : LATCH_CYC;
   localparam int MAX_B = (STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC;
   localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CW    = (MAX_T > 1) ? $clog2(MAX_T) : 1;

   mb_state_e       st_q, st_d;
   logic [CW-1:0]   cnt_q, cnt_d;
   logic            we_q;
   logic            done_q;
   logic            cnt_zero;

   assign cnt_zero = (cnt_q == '0);

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      unique case (st_q)
         ST_IDLE: if (start_i) begin
            st_d  = ST_ADDR;
            cnt_d = CW'(ADDR_CYC - 1);
         end
         ST_ADDR: if (cnt_zero) begin
            st_d  = ST_LATCH;
            cnt_d = CW'(LATCH_CYC - 1);
         end else cnt_d = cnt_q - CW'(1);
         ST_LATCH: if (cnt_zero) st_d = ST_TURN;
                   else cnt_d = cnt_q - CW'(1);
         ST_TURN: begin
            st_d  = ST_STROBE;
            cnt_d = CW'(STROBE_CYC - 1);
         end
         ST_STROBE: if (cnt_zero) begin
            st_d  = ST_HOLD;
            cnt_d = CW'(HOLD_CYC - 1);
         end else cnt_d = cnt_q - CW'(1);
         ST_HOLD: if (cnt_zero) st_d = ST_IDLE;
                  else cnt_d = cnt_q - CW'(1);
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         we_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         cnt_q  <= cnt_d;
         done_q <= (st_q == ST_HOLD) && cnt_zero;
         if (st_q == ST_IDLE && start_i) we_q <= we_i;
      end
   end

   always_comb begin
      ctl_o = '0;
      unique case (st_q)
         ST_ADDR:   begin ctl_o.ale = 1'b1; ctl_o.oe = 1'b1; end
         ST_LATCH:  ctl_o.oe = 1'b1;
         ST_TURN:   begin ctl_o.oe = we_q; ctl_o.sel_data = 1'b1; end
         ST_STROBE: begin
            ctl_o.rd_act   = !we_q;
            ctl_o.wr_act   = we_q;
            ctl_o.oe       = we_q;
            ctl_o.sel_data = 1'b1;
         end
         ST_HOLD:   begin ctl_o.oe = we_q; ctl_o.sel_data = 1'b1; end
         default:   ctl_o = '0;
      endcase
   end

   assign cap_o   = (st_q == ST_STROBE) && cnt_zero && !we_q;
   assign done_o  = done_q;
   assign state_o = st_q;
endmodule

// File: rtl/muxbus_pins.sv
module muxbus_pins #(
   parameter int ADDR_W = 12,
   parameter int LO_W   = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [LO_W-1:0]   wdata_i,
   input  logic              cap_i,
   input  logic              sel_data_i,
   input  logic [LO_W-1:0]   ad_i,
   input  logic              wide_i,
   input  logic [ADDR_W-LO_W-1:0] gpio_hi_i,
   output logic [LO_W-1:0]   ad_o,
   output logic [LO_W-1:0]   rdata_o,
   output logic [ADDR_W-LO_W-1:0] hi_o
);
   localparam int HI_W = ADDR_W - LO_W;

   logic [ADDR_W-1:0] addr_q;
   logic [LO_W-1:0]   wdata_q;
   logic [LO_W-1:0]   rdata_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         if (start_i) begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
         end
         if (cap_i) rdata_q <= ad_i;
      end
   end

   assign ad_o    = sel_data_i ? wdata_q : addr_q[LO_W-1:0];
   assign rdata_o = rdata_q;

   for (genvar b = 0; b < HI_W; b++) begin : g_hi
      assign hi_o[b] = wide_i ? addr_q[LO_W+b] : gpio_hi_i[b];
   end
endmodule

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl
   import muxbus_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int LO_W       = 8,
   parameter int ADDR_CYC   = 2,
   parameter int LATCH_CYC  = 1,
   parameter int STROBE_CYC = 3,
   parameter int HOLD_CYC   = 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [LO_W-1:0]   wdata_i,
   output logic [LO_W-1:0]   rdata_o,
   output logic              done_o,
   output logic              idle_o,
   input  logic              wide_i,
   input  logic [ADDR_W-LO_W-1:0] gpio_hi_i,
   output logic              ale_o,
   output logic              rd_no,
   output logic              wr_no,
   output logic [LO_W-1:0]   ad_o,
   output logic              ad_oe_o,
   input  logic [LO_W-1:0]   ad_i,
   output logic [ADDR_W-LO_W-1:0] hi_o
);
   if (ADDR_W <= LO_W)  begin : g_bad_w $error("ADDR_W must exceed LO_W"); end
   if (ADDR_CYC < 1)    begin : g_bad_a $error("ADDR_CYC must be >= 1"); end
   if (LATCH_CYC < 1)   begin : g_bad_l $error("LATCH_CYC must be >= 1"); end
   if (STROBE_CYC < 1)  begin : g_bad_s $error("STROBE_CYC must be >= 1"); end
   if (HOLD_CYC < 1)    begin : g_bad_h $error("HOLD_CYC must be >= 1"); end

   mb_state_e state;
   mb_ctl_t   ctl;
   logic      start;
   logic      cap;

   assign idle_o = (state == ST_IDLE);
   assign start  = req_i && idle_o;

   muxbus_seq #(
      .ADDR_CYC  (ADDR_CYC),
      .LATCH_CYC (LATCH_CYC),
      .STROBE_CYC(STROBE_CYC),
      .HOLD_CYC  (HOLD_CYC)
   ) u_seq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(start),
      .we_i   (we_i),
      .state_o(state),
      .ctl_o  (ctl),
      .cap_o  (cap),
      .done_o (done_o)
   );

   muxbus_pins #(
      .ADDR_W(ADDR_W),
      .LO_W  (LO_W)
   ) u_pins (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start),
      .addr_i    (addr_i),
      .wdata_i   (wdata_i),
      .cap_i     (cap),
      .sel_data_i(ctl.sel_data),
      .ad_i      (ad_i),
      .wide_i    (wide_i),
      .gpio_hi_i (gpio_hi_i),
      .ad_o      (ad_o),
      .rdata_o   (rdata_o),
      .hi_o      (hi_o)
   );

   assign ale_o   = ctl.ale;
   assign rd_no   = !ctl.rd_act;
   assign wr_no   = !ctl.wr_act;
   assign ad_oe_o = ctl.oe;
endmodule

// File: rtl/muxbus_chk.sv
module muxbus_chk #(
   parameter int LO_W = 8,
   parameter int HI_W = 4
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            wide_i,
   input logic [HI_W-1:0] gpio_hi_i,
   input logic            ale_o,
   input logic            rd_no,
   input logic            wr_no,
   input logic            ad_oe_o,
   input logic            done_o,
   input logic            idle_o,
   input logic [HI_W-1:0] hi_o
);
   p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      idle_o |-> (!ale_o && rd_no && wr_no && !ad_oe_o));

   p_ale_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ale_o) |-> (rd_no && wr_no) ##1 (rd_no && wr_no));

   p_write_drives_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_no |-> ad_oe_o);

   p_read_released_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_no |-> !ad_oe_o);

   p_read_turn_after_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rd_no) |-> !ad_oe_o);

   p_read_turn_before_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_no && !ad_oe_o && !idle_o && !ale_o) |=> (rd_no || !ad_oe_o));

   p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> idle_o);

   p_hi_gpio_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wide_i |-> (hi_o == gpio_hi_i));

   p_hi_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wide_i && !idle_o && $past(!idle_o)) |-> $stable(hi_o));

   p_one_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones({!rd_no, !wr_no}) <= 1);

   p_no_ale_in_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rd_no || !wr_no) |-> !ale_o);
endmodule

bind muxbus_ctrl muxbus_chk #(
   .LO_W(LO_W),
   .HI_W(ADDR_W - LO_W)
) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .wide_i   (wide_i),
   .gpio_hi_i(gpio_hi_i),
   .ale_o    (ale_o),
   .rd_no    (rd_no),
   .wr_no    (wr_no),
   .ad_oe_o  (ad_oe_o),
   .done_o   (done_o),
   .idle_o   (idle_o),
   .hi_o     (hi_o)
);

// File: tb/muxbus_ctrl_tb.sv
module muxbus_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int T_A = 2, T_L = 1, T_S = 3, T_H = 1;
   localparam int STROBE_AT = T_A + T_L + 2;
   localparam int LAT = T_A + T_L + T_S + T_H + 2;
   localparam int MAX_CYC = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, we = 1'b0, wide = 1'b1;
   logic [11:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [3:0]  gpio = 4'h5;
   logic [7:0]  rdata, ad_out, ad_in;
   logic        done, idle, ale, rd_n, wr_n, oe;
   logic [3:0]  hi;

   int n_chk = 0, n_bad = 0, n_done = 0, n_xfer = 0;
   int contend = 0, turn_pre = 0, turn_post = 0;
   logic prev_rd_n = 1'b1, prev_oe = 1'b0;
   bit   finished = 0;

   logic [7:0] mem     [0:4095];
   logic [7:0] ref_mem [0:4095];
   logic [7:0] lat_lo;
   logic [11:0] ext_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   muxbus_ctrl #(
      .ADDR_CYC(T_A), .LATCH_CYC(T_L), .STROBE_CYC(T_S), .HOLD_CYC(T_H)
   ) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .idle_o(idle),
      .wide_i(wide), .gpio_hi_i(gpio), .ale_o(ale), .rd_no(rd_n), .wr_no(wr_n),
      .ad_o(ad_out), .ad_oe_o(oe), .ad_i(ad_in), .hi_o(hi)
   );

   // external transparent latch and memory
   always @* if (ale) lat_lo = ad_out;
   assign ext_addr = wide ? {hi, lat_lo} : {4'h0, lat_lo};
   assign ad_in = !rd_n ? mem[ext_addr] : 8'hEE;
   always @(posedge wr_n) if (oe) mem[ext_addr] = ad_out;

   function automatic logic [11:0] eff(input logic [11:0] a, input logic w);
      return w ? a : {4'h0, a[7:0]};
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   // bus monitor
   always @(negedge clk) if (rst_n) begin
      if (oe && !rd_n) contend++;
      if (!rd_n && prev_rd_n && prev_oe) turn_pre++;
      if (rd_n && !prev_rd_n && oe) turn_post++;
      if (done) n_done++;
      prev_rd_n = rd_n;
      prev_oe   = oe;
   end

   task automatic xfer(input logic w, input logic [11:0] a, input logic [7:0] d,
                       input logic md, input bit inject);
      int ale_cnt = 0, stb_cnt = 0, first_stb = 0, done_at = 0, ale_last = 0;
      bit ale_ok = 1, wd_ok = 1;
      logic [11:0] ea = eff(a, md);
      logic [7:0]  exp_rd = ref_mem[ea];
      @(negedge clk);
      wide = md;
      chk(idle == 1'b1, "R1 idle before request", idle, 1);
      req = 1'b1; we = w; addr = a; wdata = d;
      @(negedge clk);
      req = 1'b0;
      n_xfer++;
      for (int k = 1; k <= LAT + 1; k++) begin
         if (ale) begin
            ale_cnt++; ale_last = k;
            if (!(oe && ad_out == a[7:0])) ale_ok = 0;
         end
         if (k == ale_last + 1 && k > 1 && k <= ale_last + T_L && !(oe && ad_out == a[7:0]))
            ale_ok = 0;
         if (!rd_n || !wr_n) begin
            stb_cnt++;
            if (first_stb == 0) begin
               first_stb = k;
               chk(lat_lo == a[7:0], "R3 latched low address", lat_lo, a[7:0]);
               chk(hi == (md ? a[11:8] : gpio), "R9 upper pins", hi, md ? a[11:8] : gpio);
            end
            if (w && wr_n) wd_ok = 0;
            if (!w && rd_n) wd_ok = 0;
         end
         if (w && k >= STROBE_AT - 1 && k < LAT && !(oe && ad_out == d)) wd_ok = 0;
         if (done) done_at = k;
         if (inject && k == 2) begin
            req = 1'b1; we = 1'b1; addr = 12'h0F0; wdata = 8'h99;
         end
         if (inject && k == 3) req = 1'b0;
         if (k == LAT) begin
            chk(idle == 1'b1, "R7 idle with done", idle, 1);
            if (!w) chk(rdata == exp_rd, "R6 read data", rdata, exp_rd);
         end
         if (k == LAT + 1) chk(done == 1'b0, "R7 done one cycle", done, 0);
         @(negedge clk);
      end
      chk(ale_ok && ale_cnt == T_A, "R2 address phase", ale_cnt, T_A);
      chk(first_stb == STROBE_AT, "R3 strobe start", first_stb, STROBE_AT);
      chk(stb_cnt == T_S && wd_ok, w ? "R4 write strobe/data" : "R5 read strobe", stb_cnt, T_S);
      chk(done_at == LAT, "R7 done latency", done_at, LAT);
      if (w) ref_mem[ea] = d;
   endtask

   initial begin
      int cyc = 0;
      while (cyc < MAX_CYC) begin
         @(posedge clk);
         cyc++;
      end
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, MAX_CYC);
      summary();
   end

   initial begin
      for (int i = 0; i < 4096; i++) begin
         mem[i]     = 8'((i * 37) ^ (i >> 4));
         ref_mem[i] = 8'((i * 37) ^ (i >> 4));
      end
      void'($urandom(32'd1357));
      repeat (2) @(negedge clk);
      chk(!ale && rd_n && wr_n && !oe && !done, "R1 outputs in reset",
          {ale, rd_n, wr_n, oe, done}, 5'b01100);
      rst_n = 1'b1;
      @(negedge clk);
      chk(idle && !ale && rd_n && wr_n && !oe && !done, "R1 idle after reset",
          {idle, ale, rd_n, wr_n, oe, done}, 6'b101100);

      // directed corners
      xfer(1'b0, 12'h000, 8'h00, 1'b1, 0);
      xfer(1'b1, 12'hFFF, 8'hA5, 1'b1, 0);
      xfer(1'b0, 12'hFFF, 8'h00, 1'b1, 0);
      xfer(1'b1, 12'h3C3, 8'h00, 1'b1, 0);
      xfer(1'b0, 12'h3C3, 8'hFF, 1'b1, 0);
      gpio = 4'hA;
      xfer(1'b1, 12'h7AB, 8'h5A, 1'b0, 0);  // R9 narrow: lands at 0x0AB
      xfer(1'b0, 12'h0AB, 8'h00, 1'b0, 0);
      xfer(1'b0, 12'h7AB, 8'h00, 1'b1, 0);  // wide view of untouched 0x7AB
      // R8 request while busy must be ignored
      xfer(1'b0, 12'h222, 8'h00, 1'b1, 1);
      xfer(1'b0, 12'h0F0, 8'h00, 1'b1, 0);
      chk(n_done == n_xfer, "R8 no extra done", n_done, n_xfer);

      for (int t = 0; t < 300; t++) begin
         gpio = 4'($urandom);
         xfer(1'($urandom), 12'($urandom), 8'($urandom), 1'($urandom),
              ($urandom % 8) == 0);
      end

      chk(n_done == n_xfer, "R8 done count", n_done, n_xfer);
      chk(contend == 0, "R5 no drive during read strobe", contend, 0);
      chk(turn_pre == 0, "R5 turnaround before strobe", turn_pre, 0);
      chk(turn_post == 0, "R5 turnaround after strobe", turn_post, 0);
      summary();
   end
endmodule